// File: doc/BRIEF.md
# Read-Launched Sampling Controller

This block sits between a 32-bit register bus and a converter front end. The converter measures one of several multiplexed touch-panel and analog inputs. Software selects the input by writing a route code into a switch register. That register is guarded by a one-shot key, so a stray store cannot reroute the front end.

Software obtains a sample by reading the result register. The read returns the word currently held and, as a side effect, discards it and requests a fresh conversion. The controller pulses a start strobe to the converter. It never lets two starts come closer together than the conversion period allowed by the selected clock divisor. It stores the sample carried by the converter's done pulse.

A settling window opens on every accepted route change. A sample that completes inside that window is stored without its ready flag. All timing is counted in system clock cycles, scaled by a cycles-per-microsecond parameter.

Top module: `rdconv_adc_ctrl`

## Requirements
- R1: After reset, `sw_route` is 0, `bus_rdata` is 0, the key is not armed, no conversion is in progress or waiting, and `cnv_start` stays low until a result read arrives. The first result read returns bit 31 clear.
- R2: A write to offset 0x18 loads the low 12 bits of the write data into the route code, and `sw_route` shows the new code after that edge. The write is accepted only when the most recent bus access before it was a write of exactly 0x000000AA to offset 0x20. Idle cycles in between do not disarm the key, and an accepted write disarms it.
- R3: Any other bus access made after the key write disarms the key. This covers a read of any offset, a write to another offset, and a key write with a different value. A switch write made while the key is not armed changes neither `sw_route` nor the read-back value.
- R4: Read data is registered and appears on `bus_rdata` in the cycle after the read strobe. Offset 0x08 returns the ready flag in bit 31, zeros in bits 30:16 and the 16-bit two's-complement sample in bits 15:0. Offset 0x18 returns the route code zero-extended. Every other offset returns 0.
- R5: A read of offset 0x08 while no conversion is in progress or waiting clears the ready flag and requests a conversion. If the rate hold-off has expired, `cnv_start` is high for exactly one cycle, one cycle after the read data appears.
- R6: A read of offset 0x08 while a conversion is in progress or waiting returns bit 31 clear. It issues no extra start and does not abort the conversion, whose done pulse still delivers a ready sample.
- R7: A `cnv_done` pulse while a conversion is in progress stores `cnv_data` and sets the ready flag when the front end has settled. A `cnv_done` pulse with no conversion in progress is ignored and leaves the stored result and flag unchanged.
- R8: Every accepted switch write opens a settling window of SETTLE cycles: 500 us (divisor 4) or 2000 us (divisor 16), times `CYC_PER_US`. A conversion that completes inside the window leaves the ready flag clear.
- R9: Consecutive starts are at least GAP cycles apart: ceil(1e6/3750) = 267 us (divisor 4) or ceil(1e6/925) = 1082 us (divisor 16), times `CYC_PER_US`. A request made during the hold-off is held and issued exactly GAP cycles after the previous start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sw_route | output | SW_W | Active route code driving the analog switch matrix |
| cnv_start | output | 1 | One-cycle conversion start strobe |
| cnv_done | input | 1 | One-cycle conversion complete strobe |
| cnv_data | input | 16 | Two's-complement sample valid with `cnv_done` |

## Verification
A key flag left armed appears on `sw_route` one edge after an unkeyed switch store. A key flag stuck clear hides a properly keyed store just as quickly. A stale in-progress or waiting state appears as a missing `cnv_start` one cycle after the read data returns, or as an extra start during a conversion. A wrong hold-off count shows up as a deferred start that is not exactly 267 cycles (at one cycle per microsecond) after the one before it. A settling counter that expires early or late shows only when the stored result is read next, in bit 31 of that word.

// File: rtl/rdconv_adc_pkg.sv
package rdconv_adc_pkg;

  localparam int SAMPLE_W  = 16;
  localparam int READY_POS = 31;

  // Offsets seen by software; the key must precede the switch write.
  localparam logic [7:0]  OFF_RESULT = 8'h08;
  localparam logic [7:0]  OFF_SWITCH = 8'h18;
  localparam logic [7:0]  OFF_KEY    = 8'h20;
  localparam logic [31:0] KEY_WORD   = 32'h0000_00AA;

  // Settling time after a route change, in microseconds.
  function automatic int unsigned settle_us(input bit slow_div);
    return slow_div ? 32'd2000 : 32'd500;
  endfunction

  // Conversions per second for the selected divisor.
  function automatic int unsigned rate_sps(input bit slow_div);
    return slow_div ? 32'd925 : 32'd3750;
  endfunction

  // Minimum start-to-start spacing in microseconds, rounded up.
  function automatic int unsigned period_us(input bit slow_div);
    int unsigned r;
    r = rate_sps(slow_div);
    return (32'd1000000 + r - 32'd1) / r;
  endfunction

  function automatic logic [31:0] pack_result(input logic ready,
                                              input logic [SAMPLE_W-1:0] smp);
    logic [31:0] w;
    w = '0;
    w[READY_POS] = ready;
    w[SAMPLE_W-1:0] = smp;
    return w;
  endfunction

endpackage

// File: rtl/rdconv_countdown.sv
module rdconv_countdown #(
  parameter int          W    = 8,
  parameter int unsigned LOAD = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic idle
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= W'(LOAD);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - W'(1);
  end

  assign idle = (cnt_q == '0);

endmodule

// File: rtl/rdconv_key_guard.sv
module rdconv_key_guard
  import rdconv_adc_pkg::*;
#(
  parameter int AW   = 8,
  parameter int SW_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [31:0]     bus_wdata,
  output logic [SW_W-1:0] sw_q,
  output logic            sw_accept,
  output logic            unlock_q
);

  logic any_access;
  logic key_hit;
  logic sw_hit;

  assign any_access = bus_wr | bus_rd;
  assign key_hit    = bus_wr && (bus_addr == AW'(OFF_KEY)) && (bus_wdata == KEY_WORD);
  assign sw_hit     = bus_wr && (bus_addr == AW'(OFF_SWITCH));
  assign sw_accept  = sw_hit && unlock_q;

  // Each access re-evaluates the key; idle cycles leave it as is.
  always_ff @(posedge clk) begin
    if (!rst_n)
      unlock_q <= 1'b0;
    else if (any_access)
      unlock_q <= key_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sw_q <= '0;
    else if (sw_accept)
      sw_q <= bus_wdata[SW_W-1:0];
  end

endmodule

// File: rtl/rdconv_conv_seq.sv
module rdconv_conv_seq
  import rdconv_adc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                gap_idle,
  input  logic                settle_idle,
  input  logic                cnv_done,
  input  logic [SAMPLE_W-1:0] cnv_data,
  output logic                start_go,
  output logic                cnv_start,
  output logic                busy,
  output logic                res_valid,
  output logic [SAMPLE_W-1:0] res_sample
);

  logic pending_q;
  logic accept_req;

  // A request counts only when nothing is already waiting or running.
  assign accept_req = req && !busy && !pending_q;
  assign start_go   = pending_q && !busy && gap_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      busy      <= 1'b0;
      cnv_start <= 1'b0;
    end else begin
      cnv_start <= start_go;
      if (accept_req)
        pending_q <= 1'b1;
      else if (start_go)
        pending_q <= 1'b0;
      if (start_go)
        busy <= 1'b1;
      else if (cnv_done)
        busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_sample <= '0;
    end else if (accept_req) begin
      res_valid <= 1'b0;
    end else if (cnv_done && busy) begin
      res_valid  <= settle_idle;
      res_sample <= cnv_data;
    end
  end

endmodule

// File: rtl/rdconv_adc_ctrl.sv
module rdconv_adc_ctrl
  import rdconv_adc_pkg::*;
#(
  parameter int AW         = 8,
  parameter int SW_W       = 12,
  parameter int CYC_PER_US = 50,
  parameter int SLOW_CLK   = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [SW_W-1:0]     sw_route,
  output logic                cnv_start,
  input  logic                cnv_done,
  input  logic [SAMPLE_W-1:0] cnv_data
);

  localparam bit          SLOW       = (SLOW_CLK != 0);
  localparam int unsigned SETTLE_CYC = settle_us(SLOW) * CYC_PER_US;
  localparam int unsigned GAP_CYC    = period_us(SLOW) * CYC_PER_US;
  localparam int          SETTLE_W   = $clog2(SETTLE_CYC + 1);
  localparam int          GAP_W      = $clog2(GAP_CYC + 1);

  logic                rd_result;
  logic                sw_accept;
  logic                unlock_q;
  logic                start_go;
  logic                busy;
  logic                res_valid;
  logic                settle_idle;
  logic                gap_idle;
  logic [SAMPLE_W-1:0] res_sample;
  logic [SW_W-1:0]     sw_q;
  logic [31:0]         rdata_next;
  logic [31:0]         rdata_q;

  assign rd_result = bus_rd && (bus_addr == AW'(OFF_RESULT));

  rdconv_key_guard #(.AW(AW), .SW_W(SW_W)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .sw_q      (sw_q),
    .sw_accept (sw_accept),
    .unlock_q  (unlock_q)
  );

  // Loaded with N-1 so the window closes exactly N cycles after the load.
  rdconv_countdown #(.W(SETTLE_W), .LOAD(SETTLE_CYC - 1)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sw_accept),
    .idle  (settle_idle)
  );

  rdconv_countdown #(.W(GAP_W), .LOAD(GAP_CYC - 1)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_go),
    .idle  (gap_idle)
  );

  rdconv_conv_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (rd_result),
    .gap_idle    (gap_idle),
    .settle_idle (settle_idle),
    .cnv_done    (cnv_done),
    .cnv_data    (cnv_data),
    .start_go    (start_go),
    .cnv_start   (cnv_start),
    .busy        (busy),
    .res_valid   (res_valid),
    .res_sample  (res_sample)
  );

  always_comb begin
    rdata_next = '0;
    if (bus_addr == AW'(OFF_RESULT))
      rdata_next = pack_result(res_valid, res_sample);
    else if (bus_addr == AW'(OFF_SWITCH))
      rdata_next[SW_W-1:0] = sw_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (bus_rd)
      rdata_q <= rdata_next;
  end

  assign bus_rdata = rdata_q;
  assign sw_route  = sw_q;

endmodule

// File: rtl/rdconv_adc_checker.sv
module rdconv_adc_checker
  import rdconv_adc_pkg::*;
#(
  parameter int AW   = 8,
  parameter int SW_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [AW-1:0]   bus_addr,
  input logic [14:0]     rdata_mid,
  input logic [SW_W-1:0] sw_route,
  input logic            cnv_start,
  input logic            cnv_done,
  input logic            busy,
  input logic            res_valid,
  input logic            settle_idle,
  input logic            gap_idle,
  input logic            unlock_q
);

  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |=> !cnv_start)
    else $error("start strobe longer than one cycle");

  assert_no_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !cnv_start)
    else $error("start issued while a conversion runs");

  assert_ready_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> ($past(cnv_done) && $past(busy)))
    else $error("ready rose without a done during a conversion");

  assert_ready_settled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(settle_idle))
    else $error("ready rose inside the settling window");

  assert_start_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> $past(gap_idle))
    else $error("start issued inside the rate hold-off");

  assert_switch_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_route) |-> ($past(bus_wr) && ($past(bus_addr) == AW'(OFF_SWITCH)) && $past(unlock_q)))
    else $error("route changed without a keyed switch write");

  assert_result_layout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_rd) && ($past(bus_addr) == AW'(OFF_RESULT))) |-> (rdata_mid == '0))
    else $error("result word carries nonzero middle bits");

endmodule

bind rdconv_adc_ctrl rdconv_adc_checker #(.AW(AW), .SW_W(SW_W)) u_check (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .rdata_mid   (bus_rdata[30:16]),
  .sw_route    (sw_route),
  .cnv_start   (cnv_start),
  .cnv_done    (cnv_done),
  .busy        (busy),
  .res_valid   (res_valid),
  .settle_idle (settle_idle),
  .gap_idle    (gap_idle),
  .unlock_q    (unlock_q)
);

// File: tb/test_rdconv_adc_ctrl.sv
module test_rdconv_adc_ctrl;

  localparam int AW         = 8;
  localparam int SW_W       = 12;
  localparam int CPU        = 1;
  localparam int SETTLE_CYC = 500 * CPU;
  localparam int GAP_CYC    = ((1000000 + 3750 - 1) / 3750) * CPU;
  localparam logic [7:0] A_RES = 8'h08;
  localparam logic [7:0] A_SW  = 8'h18;
  localparam logic [7:0] A_KEY = 8'h20;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [SW_W-1:0] sw_route;
  logic            cnv_start;
  logic            cnv_done = 1'b0;
  logic [15:0]     cnv_data = '0;

  int total = 0, bad = 0;
  int starts = 0, replied = 0, cyc = 0, last_start = 0;

  always #10 clk = ~clk;

  rdconv_adc_ctrl #(.AW(AW), .SW_W(SW_W), .CYC_PER_US(CPU), .SLOW_CLK(0)) i_rdconv_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sw_route(sw_route),
    .cnv_start(cnv_start), .cnv_done(cnv_done), .cnv_data(cnv_data)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (rst_n && cnv_start) begin
      starts     <= starts + 1;
      last_start <= cyc;
    end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] r);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    r = bus_rdata;
    bus_rd = 1'b0; bus_addr = '0;
  endtask

  task automatic pulse_done(input logic [15:0] s);
    @(negedge clk);
    cnv_data = s; cnv_done = 1'b1;
    @(negedge clk);
    cnv_done = 1'b0;
  endtask

  task automatic wait_starts(input int n, input string req);
    int w;
    w = 0;
    while (starts < n && w < 5000) begin
      @(negedge clk); #1;
      w++;
    end
    if (starts < n) check(req, "start never issued", starts, n);
  endtask

  task automatic finish_conv(input logic [15:0] s);
    wait_starts(replied + 1, "R5");
    replied++;
    pulse_done(s);
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    check("R1", "read data after reset", bus_rdata, 32'h0);
    check("R1", "route after reset", {20'h0, sw_route}, 32'h0);
    repeat (20) @(negedge clk);
    #1 check("R1", "no start without a read", starts, 0);
  endtask

  task automatic t_basic;
    logic [31:0] r;
    int s1;
    bus_read(A_RES, r);
    check("R1", "first result word", r, 32'h0);
    @(negedge clk); #1;
    check("R5", "start count after read", starts, 1);
    check("R5", "start high one cycle after data", {31'h0, cnv_start}, 32'h1);
    s1 = last_start;
    @(negedge clk); #1;
    check("R5", "start lasts one cycle", {31'h0, cnv_start}, 32'h0);
    finish_conv(16'hFB2E);
    bus_read(A_RES, r);
    check("R4", "R7 negative sample with ready", r, 32'h8000FB2E);
    wait_starts(2, "R9");
    check("R9", "deferred start spacing", last_start - s1, GAP_CYC);
  endtask

  task automatic t_busy;
    logic [31:0] r;
    bus_read(A_RES, r);
    check("R6", "ready during conversion", {31'h0, r[31]}, 32'h0);
    repeat (30) @(negedge clk);
    #1 check("R6", "no extra start while busy", starts, 2);
    finish_conv(16'h61A8);
    bus_read(A_RES, r);
    check("R6", "conversion survived busy read", r, 32'h800061A8);
    bus_read(A_RES, r);
    check("R5", "ready cleared by relaunch", {31'h0, r[31]}, 32'h0);
    wait_starts(3, "R6");
    repeat (40) @(negedge clk);
    #1 check("R6", "read while waiting adds no start", starts, 3);
  endtask

  task automatic t_lock;
    logic [31:0] r;
    bus_write(A_SW, 32'h608);
    check("R3", "unkeyed write ignored", {20'h0, sw_route}, 32'h0);
    bus_read(A_SW, r);
    check("R3", "unkeyed readback", r, 32'h0);
    bus_write(A_KEY, 32'hAA);
    bus_read(8'h00, r);
    check("R4", "unmapped offset reads zero", r, 32'h0);
    bus_write(A_SW, 32'h608);
    check("R3", "read cancels key", {20'h0, sw_route}, 32'h0);
    bus_write(A_KEY, 32'hAA);
    bus_write(8'h10, 32'h5);
    bus_write(A_SW, 32'h608);
    check("R3", "other write cancels key", {20'h0, sw_route}, 32'h0);
    bus_write(A_KEY, 32'hAB);
    bus_write(A_SW, 32'h608);
    check("R3", "wrong key value", {20'h0, sw_route}, 32'h0);
    bus_write(A_KEY, 32'hAA);
    bus_write(A_SW, 32'h680);
    check("R2", "keyed write accepted", {20'h0, sw_route}, 32'h680);
    bus_write(A_SW, 32'h640);
    check("R2", "key is one-shot", {20'h0, sw_route}, 32'h680);
    bus_read(A_SW, r);
    check("R4", "route readback", r, 32'h680);
    bus_write(A_KEY, 32'hAA);
    repeat (5) @(negedge clk);
    bus_write(A_SW, 32'h0000F620);
    check("R2", "idle keeps key, low bits taken", {20'h0, sw_route}, 32'h620);
    bus_read(A_KEY, r);
    check("R4", "key offset reads zero", r, 32'h0);
  endtask

  task automatic t_settle;
    logic [31:0] r;
    finish_conv(16'h1111);
    bus_read(A_RES, r);
    check("R8", "sample inside settle window not ready", {31'h0, r[31]}, 32'h0);
    repeat (SETTLE_CYC + 100) @(negedge clk);
    finish_conv(16'h2222);
    bus_read(A_RES, r);
    check("R8", "sample after settling ready", r, 32'h80002222);
  endtask

  task automatic t_stray;
    logic [31:0] r;
    finish_conv(16'h3333);
    bus_read(A_RES, r);
    check("R7", "stored sample", r, 32'h80003333);
    finish_conv(16'h4444);
    repeat (3) @(negedge clk);
    pulse_done(16'h7777);
    bus_read(A_RES, r);
    check("R7", "stray done ignored", r, 32'h80004444);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_busy();
    t_lock();
    t_settle();
    t_stray();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule